// File: doc/BRIEF.md
# Serial-Bit Lookup Inner-Product Engine

This block computes a dot product between a fixed coefficient vector and a vector of variable data words, and it uses no multiplier. The coefficients are module parameters. At elaboration the block builds a lookup table with one entry for every combination of one bit from each data word. Each entry holds the sum of the coefficients whose data bit is set. A start pulse loads all data words at once. The words are then shifted out together, one bit position per cycle, starting from the least significant bit. Each cycle the bit-slice addresses the table, and the table value goes into a shift-accumulator that halves its running value after every addition. On the last slice, which holds the sign bits of the two's-complement data, the table value is subtracted instead of added.

A complete product takes one cycle per data bit. A one-cycle done pulse then marks the result, which is given at full precision as an integer. Its least significant bit weighs 2^-(COEF_W+DATA_W-2) when the coefficients and the data are read as fractions. The result stays on the output until the next product finishes.

Top module: `dai_inner_product`

## Requirements
- R1: While rst_ni is low and after it is released, done_o is 0 and result_o is 0 until the first product completes.
- R2: If start_i is seen high at a rising edge while the block is idle, done_o is high for exactly one cycle. That cycle follows the DATA_W-th rising edge after the start edge.
- R3: On the done cycle, result_o is the signed sum of coefficient(i) × data(i), in integer units. Data word i sits in data_i[i*DATA_W +: DATA_W] and is two's complement.
- R4: The sign bit of each data word has weight -2^(DATA_W-1). A data word of -2^(DATA_W-1) gives -coefficient × 2^(DATA_W-1).
- R5: The table entry for each bit-slice address equals the sum of the coefficients whose bit is set. Term 1 is the most significant address bit. With default coefficients 33, 85 and -11, the entries for addresses 0 to 7 are 0, -11, 85, 74, 33, 22, 118, 107. When every word is 0 or 1, the result shows this entry.
- R6: A start_i pulse while a product is in progress is ignored. It does not change the done timing or the result of that product.
- R7: result_o changes only on a done cycle and holds its value between done pulses.
- R8: A start_i on the done cycle itself is accepted, so products can run back to back with no idle cycle.
- R9: Full-scale data of either sign on every term gives the exact result, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load data and begin a product (idle only) |
| data_i | input | N_TERMS*DATA_W | Packed two's-complement data words, term 1 in the low slice |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | DATA_W+COEF_W+$clog2(N_TERMS) | Full-precision signed inner product |

## Verification
The hardest case to reach is a start pulse that arrives while a product is still running. The engine must ignore it, yet the same input accepted on the done cycle must begin a new product at once. The stimulus pulses start with different data in the middle of a product and checks both the done timing and the result of the first product. It then starts a second product on the exact done cycle and checks that the two results arrive DATA_W+1 cycles apart. Sign-bit subtraction is isolated with words that have only their sign bit set, and each table entry is exposed with words of value 0 or 1.

// File: rtl/dai_pkg.sv
package dai_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} dai_state_e;
endpackage

// File: rtl/dai_table.sv
module dai_table #(
  parameter int unsigned N_TERMS = 3,
  parameter int unsigned COEF_W  = 8,
  parameter int unsigned TBL_W   = 10,
  parameter logic [N_TERMS*COEF_W-1:0] COEFS = '0
) (
  input  logic [N_TERMS-1:0]      addr_i,
  output logic signed [TBL_W-1:0] entry_o
);
  localparam int unsigned DEPTH = 2 ** N_TERMS;

  // term 1 drives the top address bit
  function automatic logic signed [TBL_W-1:0] part_sum(int unsigned a);
    logic signed [TBL_W-1:0]  s;
    logic signed [COEF_W-1:0] c;
    s = '0;
    for (int i = 0; i < int'(N_TERMS); i++) begin
      c = COEFS[i*COEF_W +: COEF_W];
      if (a[N_TERMS-1-i]) s = s + TBL_W'(c);
    end
    return s;
  endfunction

  logic signed [TBL_W-1:0] rom [DEPTH];

  for (genvar e = 0; e < int'(DEPTH); e++) begin : g_rom
    localparam logic signed [TBL_W-1:0] VAL = part_sum(e);
    assign rom[e] = VAL;
  end

  assign entry_o = rom[addr_i];
endmodule

// File: rtl/dai_shift_bank.sv
module dai_shift_bank #(
  parameter int unsigned N_TERMS = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        shift_i,
  input  logic [N_TERMS*DATA_W-1:0]   data_i,
  output logic [N_TERMS-1:0]          bits_o
);
  for (genvar i = 0; i < int'(N_TERMS); i++) begin : g_sr
    logic [DATA_W-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= '0;
      else if (load_i)  sr_q <= data_i[i*DATA_W +: DATA_W];
      else if (shift_i) sr_q <= {1'b0, sr_q[DATA_W-1:1]};
    end
    assign bits_o[N_TERMS-1-i] = sr_q[0];
  end
endmodule

// File: rtl/dai_shift_acc.sv
module dai_shift_acc #(
  parameter int unsigned TBL_W  = 10,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ACC_W = TBL_W + 1,
  localparam int unsigned RES_W = ACC_W + DATA_W - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    sub_i,
  input  logic signed [TBL_W-1:0] f_i,
  output logic [RES_W-1:0]        result_o
);
  logic signed [ACC_W-1:0] acc_q, sum;
  logic [DATA_W-1:0]       low_q;
  logic [RES_W-1:0]        res_q;
  logic [ACC_W-1:0]        f_ext;

  // subtract = invert plus carry-in
  assign f_ext = {f_i[TBL_W-1], f_i} ^ {ACC_W{sub_i}};
  assign sum   = acc_q + f_ext + ACC_W'(sub_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      low_q <= '0;
      res_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      low_q <= '0;
    end else if (en_i) begin
      acc_q <= sum >>> 1;
      low_q <= {sum[0], low_q[DATA_W-1:1]};
      if (sub_i) res_q <= {sum, low_q[DATA_W-1:1]};
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/dai_ctrl.sv
module dai_ctrl
  import dai_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic sub_o,
  output logic done_o
);
  dai_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign sub_o  = step_o && (cnt_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= sub_o;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (sub_o) begin
        state_q <= ST_IDLE;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/dai_inner_product.sv
module dai_inner_product #(
  parameter int unsigned N_TERMS = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned COEF_W  = 8,
  parameter logic [N_TERMS*COEF_W-1:0] COEFS = {8'shF5, 8'sd85, 8'sd33},
  localparam int unsigned TBL_W  = COEF_W + $clog2(N_TERMS),
  localparam int unsigned RES_W  = TBL_W + DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [N_TERMS*DATA_W-1:0] data_i,
  output logic                      done_o,
  output logic [RES_W-1:0]          result_o
);
  logic                    load, step, sub;
  logic [N_TERMS-1:0]      slice;
  logic signed [TBL_W-1:0] entry;

  dai_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_o(load), .step_o(step), .sub_o(sub), .done_o(done_o)
  );

  dai_shift_bank #(.N_TERMS(N_TERMS), .DATA_W(DATA_W)) bank_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .shift_i(step),
    .data_i(data_i), .bits_o(slice)
  );

  dai_table #(.N_TERMS(N_TERMS), .COEF_W(COEF_W), .TBL_W(TBL_W), .COEFS(COEFS)) tbl_i (
    .addr_i(slice), .entry_o(entry)
  );

  dai_shift_acc #(.TBL_W(TBL_W), .DATA_W(DATA_W)) acc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .en_i(step),
    .sub_i(sub), .f_i(entry), .result_o(result_o)
  );
endmodule

// File: rtl/dai_checker.sv
module dai_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RES_W  = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);
  localparam int unsigned CW = $clog2(DATA_W + 1);
  logic [CW-1:0] cnt_q;
  logic          exp_done_q;

  // independent latency model
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      exp_done_q <= 1'b0;
    end else begin
      exp_done_q <= (cnt_q == CW'(1));
      if (cnt_q == '0) begin
        if (start_i) cnt_q <= CW'(DATA_W);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_time_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_done_q |-> done_o);

  assert_no_stray_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> exp_done_q);

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

bind dai_inner_product dai_checker #(.DATA_W(DATA_W), .RES_W(RES_W)) chk_i (.*);

// File: tb/dai_inner_product_tb_top.sv
module dai_inner_product_tb_top;
  localparam int DW = 8;
  localparam int RW = 18;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [3*DW-1:0] data_i = '0;
  logic          done_o;
  logic [RW-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  dai_inner_product dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .data_i(data_i), .done_o(done_o), .result_o(result_o)
  );

  function automatic int expy(int x1, int x2, int x3);
    return 33*x1 + 85*x2 - 11*x3;
  endfunction

  function automatic int res_int();
    return int'($signed(result_o));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int x1, int x2, int x3);
    data_i  = {x3[DW-1:0], x2[DW-1:0], x1[DW-1:0]};
    start_i = 1'b1;
  endtask

  // call at a negedge; returns at the negedge where done is seen
  task automatic run_one(int x1, int x2, int x3, string req);
    int lat;
    drive(x1, x2, x3);
    lat = 0;
    do begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end while (!done_o && lat < 4*DW);
    chk(lat == DW + 1, {req, " latency"}, lat, DW + 1);
    chk(res_int() == expy(x1, x2, x3), req, res_int(), expy(x1, x2, x3));
  endtask

  task automatic t_reset();
    chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    chk(result_o == '0, "R1 result in reset", res_int(), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0 && result_o == '0, "R1 after release", res_int(), 0);
  endtask

  task automatic t_table();
    int exp_tbl [8] = '{0, -11, 85, 74, 33, 22, 118, 107};
    for (int a = 0; a < 8; a++) begin
      run_one((a >> 2) & 1, (a >> 1) & 1, a & 1, "R5 table entry");
      chk(res_int() == exp_tbl[a], "R5 table literal", res_int(), exp_tbl[a]);
      @(negedge clk_i);
    end
  endtask

  task automatic t_vectors();
    run_one(64, 0, 0, "R3 single term");
    @(negedge clk_i);
    chk(done_o == 1'b0, "R2 done one cycle", int'(done_o), 0);
    run_one(37, -90, 113, "R3 mixed");
    @(negedge clk_i);
    run_one(-5, 17, -1, "R3 small");
    @(negedge clk_i);
  endtask

  task automatic t_sign();
    run_one(-128, 0, -128, "R4 sign only");
    @(negedge clk_i);
    run_one(-1, -1, -1, "R4 all ones");
    @(negedge clk_i);
  endtask

  task automatic t_full();
    run_one(127, 127, -128, "R9 max positive");
    @(negedge clk_i);
    run_one(-128, -128, 127, "R9 max negative");
    @(negedge clk_i);
    run_one(-128, -128, -128, "R9 all min");
    @(negedge clk_i);
  endtask

  task automatic t_busy_ignore();
    int lat;
    int e;
    e = expy(50, -20, 99);
    drive(50, -20, 99);
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    drive(-7, 3, 12);
    @(negedge clk_i); start_i = 1'b0;
    lat = 4;
    while (!done_o && lat < 4*DW) begin @(negedge clk_i); lat++; end
    chk(lat == DW + 1, "R6 timing kept", lat, DW + 1);
    chk(res_int() == e, "R6 result kept", res_int(), e);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(res_int() == e && !done_o, "R7 result held", res_int(), e);
    end
  endtask

  task automatic t_back2back();
    run_one(10, 20, 30, "R8 first");
    run_one(-40, 60, -80, "R8 second");
    @(negedge clk_i);
    chk(done_o == 1'b0, "R2 single pulse", int'(done_o), 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_table();
    t_vectors();
    t_sign();
    t_full();
    t_busy_ignore();
    @(negedge clk_i);
    t_back2back();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule